// File: doc/BRIEF.md
# Gated Period-to-Frequency Measurement Unit

This block estimates the frequency of a slow external pulse train. It times half-cycles of that input with a fixed reference clock, whose nominal rate is 5 MHz. A window opens at a level change on the input. It stays open across a programmable number of further level changes, and while it is open the block counts reference-clock cycles. When the window closes, the count becomes the divisor of a bit-serial restoring division. The result is the input frequency in Hz. The block assumes a 50% duty cycle, so the full period is taken as twice the mean half-cycle.

Measurement runs back to back. The level change that closes one window opens the next one. A division takes one cycle per quotient bit. A window that finishes while the divider is busy is held in a single pending slot, and a later window replaces it. If a window runs until its counter saturates, the block reports a timeout in place of a frequency.

Top module: `fm_freq_meter`

## Requirements
- R1: While rst_n is low at a rising clock edge, and after that edge, count_o, freq_o, valid_o and ovf_o are all zero.
- R2: The count of a window is the number of reference-clock cycles from its opening level change on pulse_i to the S-th following level change. S is the effective scaler. The closing change opens the next window, and each window reports its count on count_o together with its frequency.
- R3: The reported frequency is floor(REF_HZ/2 × S / count). A half-cycle of 25 reference cycles with S = 1 yields exactly 100000.
- R4: With S = 1, half-cycles of 2, 5, 10, 20, 50 and 100 reference cycles yield 1250000, 500000, 250000, 125000, 50000 and 25000.
- R5: A scaler S greater than 1 stretches the window over S half-cycles. count_o scales by S and freq_o stays equal to the S = 1 result.
- R6: A scaler_i value of 0 behaves exactly as a value of 1.
- R7: valid_o is a single-cycle pulse. count_o and freq_o change only in a cycle where valid_o or ovf_o is high, and they hold their values otherwise.
- R8: A window that reaches 2^CNT_W − 1 counted cycles without closing raises ovf_o, forces freq_o to 0 and count_o to all ones, and produces no valid_o. The next valid result clears ovf_o. A window of exactly 2^CNT_W − 1 cycles still produces a result.
- R9: A window that closes during a division waits in one pending slot. A newer window overwrites it, so a fast input yields fewer results than windows, and every result it does yield is correct.
- R10: The first level change after reset or after a timeout only opens a window and yields no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; each rising edge is one counted cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_i | input | 1 | Asynchronous pulse train to be measured |
| scaler_i | input | SCL_W | Half-cycles per window; 0 acts as 1; read when a window opens |
| count_o | output | CNT_W | Cycle count of the window behind the last result |
| freq_o | output | quot_width(REF_HZ, SCL_W) | Measured frequency in Hz |
| valid_o | output | 1 | One-cycle strobe marking a new count_o/freq_o pair |
| ovf_o | output | 1 | Window counter saturated; freq_o forced to 0 |

## Verification
The embedded properties rely on a few conditions at the inputs. Level changes on pulse_i must be at least two reference cycles apart, so that the synchronizer turns each change into exactly one edge pulse. The division properties also rely on the zero-count guard, which keeps a zero divisor from reaching the divider. The stimulus changes pulse_i and scaler_i only on falling clock edges. It never uses a half-cycle shorter than two cycles, and it changes the scaler only while no window is open, after each burst has ended in a timeout. The correctness property on the quotient then holds for every division the bursts start, including those started from the pending slot.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
// Package fm_pkg
// Shared types and width helpers for the period-to-frequency meter.
// Assumes: reference rates are even, so REF_HZ/2 is exact.
package fm_pkg;

    // Window tracker states
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    // Quotient width: holds (ref_hz/2) * (2^scl_w - 1)
    function automatic int quot_width(input int ref_hz, input int scl_w);
        return $clog2(ref_hz / 2) + scl_w;
    endfunction

endpackage

// File: rtl/fm_sync_edge.sv
`timescale 1ns/1ps
// Module fm_sync_edge
// Brings an asynchronous level into the clock domain through a chain of
// flops, then emits a one-cycle pulse for every level change.
// Assumes: level changes are at least two clock cycles apart.
module fm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain plus a delayed copy for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign edge_o = sync_q[STAGES-1] ^ last_q;

    // Two level changes never produce back-to-back pulses (input spacing)
    p_edge_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/fm_window.sv
`timescale 1ns/1ps
// Module fm_window
// Tracks the measurement window. An edge opens it. Reference cycles are
// counted until the scaler's worth of further edges has passed. The closing
// edge reports the count and reopens at once. Saturation reports a timeout
// and drops back to idle.
// Assumes: edge_i is a single-cycle pulse per input level change.
module fm_window
    import fm_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [SCL_W-1:0] scaler_i,
    output logic             done_o,
    output logic             tmo_o,
    output logic [CNT_W-1:0] count_o,
    output logic [SCL_W-1:0] scl_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [SCL_W-1:0] SCL_ONE = SCL_W'(1);

    win_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SCL_W-1:0] left_q;
    logic [SCL_W-1:0] scl_q;
    logic [SCL_W-1:0] scl_eff;

    // Effective scaler: zero behaves as one
    always_comb scl_eff = (scaler_i == '0) ? SCL_ONE : scaler_i;

    // Window state, cycle counter and remaining-edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
            scl_q   <= '0;
            done_o  <= 1'b0;
            tmo_o   <= 1'b0;
            count_o <= '0;
            scl_o   <= '0;
        end else begin
            done_o <= 1'b0;
            tmo_o  <= 1'b0;
            case (state_q)
                WIN_IDLE: begin
                    if (edge_i) begin
                        state_q <= WIN_OPEN;
                        cnt_q   <= '0;
                        left_q  <= scl_eff;
                        scl_q   <= scl_eff;
                    end
                end
                WIN_OPEN: begin
                    if (cnt_q == CNT_MAX) begin
                        tmo_o   <= 1'b1;
                        state_q <= WIN_IDLE;
                    end else if (edge_i && left_q == SCL_ONE) begin
                        done_o  <= 1'b1;
                        count_o <= cnt_q + 1'b1;
                        scl_o   <= scl_q;
                        cnt_q   <= '0;
                        left_q  <= scl_eff;
                        scl_q   <= scl_eff;
                    end else begin
                        if (edge_i) left_q <= left_q - 1'b1;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= WIN_IDLE;
            endcase
        end
    end

    // A closed window never reports zero cycles
    p_count_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> count_o != '0);
    // An open window always expects at least one more edge
    p_left_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == WIN_OPEN |-> left_q != '0);
    // A reported scaler is never zero
    p_scl_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> scl_o != '0);
    // Result and timeout are exclusive
    p_done_tmo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && tmo_o));

endmodule

// File: rtl/fm_divider.sv
`timescale 1ns/1ps
// Module fm_divider
// Bit-serial restoring divider, one quotient bit per cycle, NUM_W cycles
// per division. done_o pulses once when quot_o is final.
// Assumes: start_i only while idle and divisor_i nonzero at start.
module fm_divider #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] dividend_i,
    input  logic [DEN_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);
    localparam int IT_W = $clog2(NUM_W + 1);
    localparam logic [IT_W-1:0] IT_ONE = IT_W'(1);

    logic [NUM_W-1:0] q_r;
    logic [NUM_W-1:0] n_r;
    logic [DEN_W-1:0] d_r;
    logic [DEN_W-1:0] rem_r;
    logic [IT_W-1:0]  it_r;
    logic [DEN_W:0]   shifted;
    logic [DEN_W+1:0] diff;
    logic             neg;

    // Trial subtraction of the divisor from the shifted remainder
    always_comb begin
        shifted = {rem_r, q_r[NUM_W-1]};
        diff    = {1'b0, shifted} - {2'b00, d_r};
        neg     = diff[DEN_W+1];
    end

    // Operand load and one restoring step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            n_r    <= '0;
            d_r    <= '0;
            rem_r  <= '0;
            it_r   <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                q_r    <= dividend_i;
                n_r    <= dividend_i;
                d_r    <= divisor_i;
                rem_r  <= '0;
                it_r   <= IT_W'(NUM_W);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (neg) begin
                    rem_r <= shifted[DEN_W-1:0];
                    q_r   <= {q_r[NUM_W-2:0], 1'b0};
                end else begin
                    rem_r <= diff[DEN_W-1:0];
                    q_r   <= {q_r[NUM_W-2:0], 1'b1};
                end
                it_r <= it_r - 1'b1;
                if (it_r == IT_ONE) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quot_o = q_r;

    // Starts only arrive while idle
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // Finished quotient and remainder reproduce the dividend exactly
    p_quot_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (64'(q_r) * 64'(d_r) + 64'(rem_r) == 64'(n_r)) && (rem_r < d_r));
    // Completion is a lone pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/fm_freq_meter.sv
`timescale 1ns/1ps
// Module fm_freq_meter (top)
// Period-to-frequency meter: synchronizer, window counter, one pending slot
// and a serial divider computing (REF_HZ/2 * scaler) / count.
// Assumes: clk is the reference clock; pulse_i half-cycles >= 2 clk cycles.
module fm_freq_meter
    import fm_pkg::*;
#(
    parameter int REF_HZ = 5_000_000,
    parameter int CNT_W  = 20,
    parameter int SCL_W  = 8,
    localparam int NUM_W = quot_width(REF_HZ, SCL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic [SCL_W-1:0] scaler_i,
    output logic [CNT_W-1:0] count_o,
    output logic [NUM_W-1:0] freq_o,
    output logic             valid_o,
    output logic             ovf_o
);
    localparam int               HALF_HZ = REF_HZ / 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             edge_s;
    logic             win_done;
    logic             win_tmo;
    logic [CNT_W-1:0] win_cnt;
    logic [SCL_W-1:0] win_scl;
    logic             win_req;
    logic             div_start;
    logic             div_busy;
    logic             div_done;
    logic [NUM_W-1:0] div_quot;
    logic [NUM_W-1:0] div_num;
    logic [CNT_W-1:0] div_den;
    logic [CNT_W-1:0] sel_cnt;
    logic [SCL_W-1:0] sel_scl;
    logic             pend_v;
    logic [CNT_W-1:0] pend_cnt;
    logic [SCL_W-1:0] pend_scl;
    logic [CNT_W-1:0] fly_cnt;
    logic             drop_r;

    fm_sync_edge #(.STAGES(2)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pulse_i),
        .edge_o (edge_s)
    );

    fm_window #(.CNT_W(CNT_W), .SCL_W(SCL_W)) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (edge_s),
        .scaler_i(scaler_i),
        .done_o  (win_done),
        .tmo_o   (win_tmo),
        .count_o (win_cnt),
        .scl_o   (win_scl)
    );

    // Launch selection: the pending slot first, then a fresh window; never zero counts
    always_comb begin
        win_req   = win_done && (win_cnt != '0);
        sel_cnt   = pend_v ? pend_cnt : win_cnt;
        sel_scl   = pend_v ? pend_scl : win_scl;
        div_start = !div_busy && !win_tmo && (pend_v || win_req);
        div_num   = NUM_W'(HALF_HZ) * NUM_W'(sel_scl);
        div_den   = sel_cnt;
    end

    fm_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .dividend_i(div_num),
        .divisor_i (div_den),
        .busy_o    (div_busy),
        .done_o    (div_done),
        .quot_o    (div_quot)
    );

    // Pending slot: holds the newest window that could not launch yet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_cnt <= '0;
            pend_scl <= '0;
        end else if (win_tmo) begin
            pend_v <= 1'b0;
        end else if (win_req && (div_busy || pend_v)) begin
            pend_v   <= 1'b1;
            pend_cnt <= win_cnt;
            pend_scl <= win_scl;
        end else if (div_start) begin
            pend_v <= 1'b0;
        end
    end

    // In-flight bookkeeping: count riding with the division, discard on timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fly_cnt <= '0;
            drop_r  <= 1'b0;
        end else if (div_start) begin
            fly_cnt <= sel_cnt;
            drop_r  <= 1'b0;
        end else if (win_tmo && div_busy) begin
            drop_r <= 1'b1;
        end
    end

    // Result registers: updated only at a finished result or a timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            freq_o  <= '0;
            valid_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (win_tmo) begin
                ovf_o   <= 1'b1;
                freq_o  <= '0;
                count_o <= CNT_MAX;
            end else if (div_done && !drop_r) begin
                freq_o  <= div_quot;
                count_o <= fly_cnt;
                valid_o <= 1'b1;
                ovf_o   <= 1'b0;
            end
        end
    end

    // Division is never launched on an empty window
    p_launch_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> div_den != '0);
    // Strobe lasts one cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // Frequency and count move only with a strobe or a timeout
    p_freq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_o) |-> valid_o || ovf_o);
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_o) |-> valid_o || ovf_o);
    // Overflow shows a zero frequency and a saturated count
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> freq_o == '0 && count_o == CNT_MAX);
    // A fresh overflow never coincides with a strobe
    p_ovf_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> !valid_o);

endmodule

// File: tb/fm_freq_meter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: run_burst pushes expected results, the monitor pops them.
module fm_freq_meter_tb_top;
    localparam int REF_HZ = 5_000_000;
    localparam int CNT_W  = 12;
    localparam int SCL_W  = 8;
    localparam int NUM_W  = fm_pkg::quot_width(REF_HZ, SCL_W);
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse = 1'b0;
    logic [SCL_W-1:0] scaler = '0;
    logic [CNT_W-1:0] count_o;
    logic [NUM_W-1:0] freq_o;
    logic             valid_o;
    logic             ovf_o;

    fm_freq_meter #(.REF_HZ(REF_HZ), .CNT_W(CNT_W), .SCL_W(SCL_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse),
        .scaler_i(scaler),
        .count_o (count_o),
        .freq_o  (freq_o),
        .valid_o (valid_o),
        .ovf_o   (ovf_o)
    );

    always #2.5 clk = ~clk;

    typedef struct { longint cnt; longint frq; } exp_t;
    exp_t   exp_q[$];
    int     n_vec = 0;
    int     n_bad = 0;
    bit     fast_mode = 1'b0;
    exp_t   fast_exp;
    int     fast_hits = 0;
    longint prev_freq = 0;
    longint prev_count = 0;
    bit     prev_valid = 1'b0;
    bit     done_flag = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: toggles pulse with the given half-cycle and queues expected results
    task automatic run_burst(input int half, input int scl, input int wins,
                             input bit fast, input bit expect_drop);
        int     eff;
        longint cnt;
        longint frq;
        eff = (scl == 0) ? 1 : scl;
        cnt = longint'(eff) * half;
        frq = (cnt == 0) ? 0 : (longint'(REF_HZ / 2) * eff) / cnt;
        scaler = SCL_W'(scl);
        if (fast) begin
            fast_exp.cnt = cnt;
            fast_exp.frq = frq;
            fast_hits = 0;
            fast_mode = 1'b1;
        end else if (cnt <= MAXC) begin
            for (int w = 0; w < wins; w++) exp_q.push_back('{cnt, frq});
        end
        for (int e = 0; e < 1 + wins * eff; e++) begin
            pulse = ~pulse;
            tick(half);
        end
        tick(MAXC + 64);
        check(ovf_o == 1'b1, "R8", "ovf after idle input", longint'(ovf_o), 1);
        check(freq_o == '0, "R8", "freq forced to zero", longint'(freq_o), 0);
        check(count_o == CNT_W'(MAXC), "R8", "count saturated", longint'(count_o), MAXC);
        check(exp_q.size() == 0, "R10", "results still outstanding", exp_q.size(), 0);
        if (fast) begin
            check(fast_hits >= 1, "R9", "results seen", fast_hits, 1);
            if (expect_drop)
                check(fast_hits < wins, "R9", "overwritten windows", fast_hits, wins - 1);
            fast_mode = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard on each strobe and watches output stability
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (valid_o) begin
                check(ovf_o == 1'b0, "R8", "ovf cleared by result", longint'(ovf_o), 0);
                if (fast_mode) begin
                    fast_hits++;
                    check(longint'(count_o) == fast_exp.cnt, "R2", "fast count",
                          longint'(count_o), fast_exp.cnt);
                    check(longint'(freq_o) == fast_exp.frq, "R4", "fast freq",
                          longint'(freq_o), fast_exp.frq);
                end else if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected result", longint'(freq_o), 0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check(longint'(count_o) == it.cnt, "R2", "count", longint'(count_o), it.cnt);
                    check(longint'(freq_o) == it.frq, "R3", "freq", longint'(freq_o), it.frq);
                end
            end
            if (valid_o && prev_valid)
                check(1'b0, "R7", "strobe longer than one cycle", 2, 1);
            if (longint'(freq_o) != prev_freq)
                check(valid_o || ovf_o, "R7", "freq moved without strobe", longint'(freq_o), prev_freq);
            if (longint'(count_o) != prev_count)
                check(valid_o || ovf_o, "R7", "count moved without strobe", longint'(count_o), prev_count);
            prev_freq  = longint'(freq_o);
            prev_count = longint'(count_o);
            prev_valid = valid_o;
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        @(posedge clk);
        #1;
        check(count_o == '0, "R1", "count in reset", longint'(count_o), 0);
        check(freq_o == '0, "R1", "freq in reset", longint'(freq_o), 0);
        check(valid_o == 1'b0, "R1", "valid in reset", longint'(valid_o), 0);
        check(ovf_o == 1'b0, "R1", "ovf in reset", longint'(ovf_o), 0);
        tick(1);
        rst_n = 1'b1;
        tick(2);
        check(freq_o == '0 && valid_o == 1'b0, "R1", "idle after reset", longint'(freq_o), 0);

        run_burst(25, 1, 3, 1'b1, 1'b0);   // R3: 25 cycles -> 100000
        run_burst(2, 1, 20, 1'b1, 1'b1);   // R4, R9: 1250000 with overwrites
        run_burst(5, 1, 10, 1'b1, 1'b1);   // R4: 500000
        run_burst(10, 1, 8, 1'b1, 1'b1);   // R4: 250000
        run_burst(20, 1, 6, 1'b1, 1'b0);   // R4: 125000
        run_burst(50, 1, 2, 1'b0, 1'b0);   // R4: 50000
        run_burst(100, 1, 2, 1'b0, 1'b0);  // R4: 25000
        run_burst(30, 4, 2, 1'b0, 1'b0);   // R5: count 120, freq 83333
        run_burst(60, 0, 2, 1'b0, 1'b0);   // R6: zero scaler as one
        run_burst(MAXC, 1, 1, 1'b0, 1'b0); // R8 boundary: last countable window
        run_burst(2048, 2, 1, 1'b0, 1'b0); // R8: 4096 cycles saturates
        run_burst(MAXC + 1, 1, 1, 1'b0, 1'b0); // R8: one past the limit
        run_burst(40, 1, 0, 1'b0, 1'b0);   // R10: lone level change, no result
        run_burst(25, 3, 2, 1'b0, 1'b0);   // R5: recovery, count 75

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule